// File: doc/BRIEF.md
# Lockable Multicart Bank Controller

This block selects the ROM banks for a multi-game cartridge on an 8-bit console. It watches the CPU address bus and the byte on the CPU data bus. An access to one of two small windows near the top of the CPU space copies that byte into a bank register. Reads count as well as writes. On a read, the byte is the one the program ROM is driving, so the cartridge can switch banks just by fetching from a chosen location.

One register is the outer register. It holds the game block, the mirroring and a mode bit. It seals itself for good once any of its six low bits is nonzero, which stops a game from leaving its block. The other register is the inner register. It holds fine pattern-bank bits and one program bit, and it stays writable at all times.

The controller drives:
- the upper program-ROM address bits for a 32 KiB window,
- the upper pattern-ROM address bits for an 8 KiB window,
- the nametable address bit that sets vertical or horizontal mirroring.

The mode bit moves one program bit and one pattern bit from the outer register to the inner register.

Top module: `mcb_top`

## Requirements
- R1: After reset both registers hold zero. This gives program bank 0, pattern bank 0, mode 0, vertical mirroring (`mirror_horiz`=0, `mode_alt`=0) and the unlocked state.
- R2: While unlocked, an access (`cpu_access`=1) with `cpu_addr` in 0xFF80..0xFF9F loads the outer register from `cpu_data` on the clock edge that ends the cycle. Outer bit 7 is the mirroring (1 = horizontal) and bit 6 is the mode.
- R3: Once any of outer bits 5..0 is 1, later accesses to the outer window leave the outer register unchanged.
- R4: A load whose bits 5..0 are all zero, such as 0xC0, does not lock. A later outer-window load still takes effect.
- R5: An access with `cpu_addr` in 0xFFE8..0xFFF8 loads the inner register with `cpu_data` AND 0x71. This works whether or not the outer register is locked.
- R6: Registers do not change for addresses outside both windows (for example 0xFF7F, 0xFFA0, 0xFFE7 and 0xFFF9), or when `cpu_access` is 0.
- R7: In mode 0, the program bank is outer[3:0] and the pattern bank is {outer[3:0], inner[5:4]}.
- R8: In mode 1, the program bank is {outer[3:1], inner[0]} and the pattern bank is {outer[3:1], inner[6:4]}.
- R9: `prg_addr` = {program bank, cpu_addr[14:0]} and `prg_ce` = cpu_addr[15]. `chr_addr` = {pattern bank, ppu_addr[12:0]}.
- R10: `ciram_a10` is ppu_addr[10] under vertical mirroring and ppu_addr[11] under horizontal mirroring.
- R11: During the access cycle itself, the addresses still use the bank selection in force before that access. The new selection appears after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers capture on the rising edge ending a bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_access | input | 1 | Qualifies a CPU bus cycle, read or write |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | Byte on the CPU data bus (ROM output on reads) |
| ppu_addr | input | 14 | PPU address bus |
| prg_ce | output | 1 | Program ROM enable (upper half of CPU space) |
| prg_addr | output | 19 | Program ROM byte address |
| chr_addr | output | 19 | Pattern ROM byte address |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |
| mirror_horiz | output | 1 | 1 when horizontal mirroring is selected |
| mode_alt | output | 1 | 1 when mode 1 is selected |

## Verification
The hardest states to reach are the ones before the lock. The outer register can be loaded only a few times before it seals, so the bench steers the unlocked phase on purpose.

First it loads a value with only the mode and mirroring bits set. That puts the block in mode 1 while it is still unlocked. The bench checks the mode-1 mapping there, then loads a locking value to confirm that the unlocked state survived the first load.

Reset is then applied mid-run so that a second locking value can exercise the mode-1 extremes. The bench also sits on the capturing access cycle itself to confirm that the old bank is still presented.

// File: rtl/mcb_pkg.sv
// Shared widths, field layouts and window bounds for the multicart bank controller.
// Assumes an 8-bit CPU data bus and a 16-bit CPU address space.
package mcb_pkg;
    localparam int CPU_AW    = 16;
    localparam int DATA_W    = 8;
    localparam int PPU_AW    = 14;
    localparam int PRG_BW    = 4;
    localparam int CHR_BW    = 6;
    localparam int PRG_OFS_W = 15;
    localparam int CHR_OFS_W = 13;
    localparam int PRG_AW    = PRG_BW + PRG_OFS_W;
    localparam int CHR_AW    = CHR_BW + CHR_OFS_W;
    localparam int SEL_W     = 6;

    localparam logic [CPU_AW-1:0] OUTER_LO = 16'hFF80;
    localparam logic [CPU_AW-1:0] OUTER_HI = 16'hFF9F;
    localparam logic [CPU_AW-1:0] INNER_LO = 16'hFFE8;
    localparam logic [CPU_AW-1:0] INNER_HI = 16'hFFF8;
    localparam logic [DATA_W-1:0] INNER_KEEP = 8'h71;

    // Outer register layout: mirroring, mode, then block select bits.
    typedef struct packed {
        logic             mirror_h;
        logic             mode_alt;
        logic [SEL_W-1:0] sel;
    } outer_t;
endpackage

// File: rtl/mcb_win_decode.sv
// Address window decoder: flags a qualified bus cycle whose address lies in [LO, HI].
// Assumes LO <= HI; purely combinational.
module mcb_win_decode
    import mcb_pkg::*;
#(
    parameter logic [CPU_AW-1:0] LO = 16'h0000,
    parameter logic [CPU_AW-1:0] HI = 16'hFFFF
) (
    input  logic              access,
    input  logic [CPU_AW-1:0] addr,
    output logic              hit
);
    // Range compare gated by the bus-cycle qualifier.
    always_comb begin
        hit = access && (addr >= LO) && (addr <= HI);
    end
endmodule

// File: rtl/mcb_bank_regs.sv
// Outer and inner bank registers. The outer register loads only while its select
// bits are zero, then locks; the inner register loads masked on every hit.
// Assumes the hit flags are already decoded and qualified by the bus cycle.
module mcb_bank_regs
    import mcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              outer_hit,
    input  logic              inner_hit,
    input  logic [DATA_W-1:0] data,
    output outer_t            outer_q,
    output logic [DATA_W-1:0] inner_q
);
    logic locked;

    // Lock state: any nonzero block-select bit seals the outer register.
    always_comb begin
        locked = |outer_q.sel;
    end

    // Outer register: synchronous clear, load on hit while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outer_q <= '0;
        end else if (outer_hit && !locked) begin
            outer_q <= outer_t'(data);
        end
    end

    // Inner register: synchronous clear, masked load on every hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inner_q <= '0;
        end else if (inner_hit) begin
            inner_q <= data & INNER_KEEP;
        end
    end

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|outer_q.sel) |=> $stable(outer_q)); // R3
    AST_INNER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (inner_q & ~INNER_KEEP) == '0); // R5
    AST_OUTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !outer_hit |=> $stable(outer_q)); // R6
    AST_INNER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !inner_hit |=> $stable(inner_q)); // R6
    AST_UNLOCKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (outer_hit && !(|outer_q.sel)) |=> (outer_q == outer_t'($past(data)))); // R2
endmodule

// File: rtl/mcb_bank_map.sv
// Bank mapper: turns register contents and bus addresses into ROM addresses and
// the nametable address bit. Mode 1 moves one program bit and one pattern bit
// from the outer register to the inner one. Purely combinational.
module mcb_bank_map
    import mcb_pkg::*;
(
    input  outer_t            outer_q,
    input  logic [DATA_W-1:0] inner_q,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic              prg_ce,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              ciram_a10
);
    localparam int BLK_W = PRG_BW - 1;

    logic [PRG_BW-1:0] prg_bank;
    logic [CHR_BW-1:0] chr_bank;
    logic [BLK_W-1:0]  block;

    // Bank selection per mode.
    always_comb begin
        block = outer_q.sel[PRG_BW-1:1];
        if (outer_q.mode_alt) begin
            prg_bank = {block, inner_q[0]};
            chr_bank = {block, inner_q[6:4]};
        end else begin
            prg_bank = outer_q.sel[PRG_BW-1:0];
            chr_bank = {outer_q.sel[PRG_BW-1:0], inner_q[5:4]};
        end
    end

    // Address composition and mirroring bit.
    always_comb begin
        prg_ce    = cpu_addr[CPU_AW-1];
        prg_addr  = {prg_bank, cpu_addr[PRG_OFS_W-1:0]};
        chr_addr  = {chr_bank, ppu_addr[CHR_OFS_W-1:0]};
        ciram_a10 = outer_q.mirror_h ? ppu_addr[11] : ppu_addr[10];
    end
endmodule

// File: rtl/mcb_top.sv
// Lockable multicart bank controller top: two window decoders, the bank
// registers and the bank mapper. Registers capture at the edge ending a
// qualified bus cycle, so the cycle's own access uses the old selection.
module mcb_top
    import mcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_access,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic [13:0]       ppu_addr,
    output logic              prg_ce,
    output logic [18:0]       prg_addr,
    output logic [18:0]       chr_addr,
    output logic              ciram_a10,
    output logic              mirror_horiz,
    output logic              mode_alt
);
    localparam int NWIN = 2;
    localparam logic [CPU_AW-1:0] WLO [NWIN] = '{OUTER_LO, INNER_LO};
    localparam logic [CPU_AW-1:0] WHI [NWIN] = '{OUTER_HI, INNER_HI};

    logic [NWIN-1:0]   hit;
    outer_t            outer_q;
    logic [DATA_W-1:0] inner_q;

    // One decoder per register window.
    for (genvar w = 0; w < NWIN; w++) begin : g_win
        mcb_win_decode #(.LO(WLO[w]), .HI(WHI[w])) u_dec (
            .access (cpu_access),
            .addr   (cpu_addr),
            .hit    (hit[w])
        );
    end

    mcb_bank_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .outer_hit (hit[0]),
        .inner_hit (hit[1]),
        .data      (cpu_data),
        .outer_q   (outer_q),
        .inner_q   (inner_q)
    );

    mcb_bank_map u_map (
        .outer_q   (outer_q),
        .inner_q   (inner_q),
        .cpu_addr  (cpu_addr),
        .ppu_addr  (ppu_addr),
        .prg_ce    (prg_ce),
        .prg_addr  (prg_addr),
        .chr_addr  (chr_addr),
        .ciram_a10 (ciram_a10)
    );

    // Mode and mirroring status straight from the outer register.
    always_comb begin
        mirror_horiz = outer_q.mirror_h;
        mode_alt     = outer_q.mode_alt;
    end

    AST_WINDOWS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit[0] && hit[1])); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (mirror_horiz == 1'b0 && mode_alt == 1'b0)); // R1
endmodule

// File: tb/tb_mcb_top.sv
// Vector-table bench for mcb_top followed by directed address and timing tests.
module tb_mcb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_access = 1'b0;
    logic [15:0] cpu_addr = 16'h8000;
    logic [7:0]  cpu_data = 8'h00;
    logic [13:0] ppu_addr = 14'h0000;
    logic        prg_ce;
    logic [18:0] prg_addr;
    logic [18:0] chr_addr;
    logic        ciram_a10;
    logic        mirror_horiz;
    logic        mode_alt;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    mcb_top dut (
        .clk(clk), .rst_n(rst_n), .cpu_access(cpu_access), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_ce(prg_ce),
        .prg_addr(prg_addr), .chr_addr(chr_addr), .ciram_a10(ciram_a10),
        .mirror_horiz(mirror_horiz), .mode_alt(mode_alt)
    );

    // Row: rst, acc, addr[16], data[8], exp prg bank[4], exp chr bank[6], exp horiz
    localparam int NV = 15;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h8000, 8'h00, 4'h0, 6'h00, 1'b0}, // R1 reset
        {1'b0, 1'b1, 16'hFF7F, 8'h05, 4'h0, 6'h00, 1'b0}, // R6 below outer window
        {1'b0, 1'b1, 16'hFFA0, 8'h05, 4'h0, 6'h00, 1'b0}, // R6 above outer window
        {1'b0, 1'b1, 16'hFF80, 8'hC0, 4'h0, 6'h00, 1'b1}, // R2 mode 1, horizontal
        {1'b0, 1'b1, 16'hFFE8, 8'h71, 4'h1, 6'h07, 1'b1}, // R8 mode-1 mapping
        {1'b0, 1'b1, 16'hFF9F, 8'h02, 4'h2, 6'h0B, 1'b0}, // R4 R7 still unlocked
        {1'b0, 1'b1, 16'hFF90, 8'h4F, 4'h2, 6'h0B, 1'b0}, // R3 locked
        {1'b0, 1'b1, 16'hFFF8, 8'h10, 4'h2, 6'h09, 1'b0}, // R5 inner while locked
        {1'b0, 1'b1, 16'hFFF9, 8'h30, 4'h2, 6'h09, 1'b0}, // R6 above inner window
        {1'b0, 1'b1, 16'hFFE7, 8'h30, 4'h2, 6'h09, 1'b0}, // R6 below inner window
        {1'b1, 1'b0, 16'h8000, 8'h00, 4'h0, 6'h00, 1'b0}, // R1 reset clears lock
        {1'b0, 1'b1, 16'hFF80, 8'h4E, 4'hE, 6'h38, 1'b0}, // R8 block 7
        {1'b0, 1'b1, 16'hFFF0, 8'hFF, 4'hF, 6'h3F, 1'b0}, // R5 R8 masked inner
        {1'b0, 1'b1, 16'hFF80, 8'h00, 4'hF, 6'h3F, 1'b0}, // R3 zero load ignored
        {1'b0, 1'b0, 16'hFFE8, 8'h00, 4'hF, 6'h3F, 1'b0}  // R6 no access qualifier
    };

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_access = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cpu_addr = 16'h8000;
        ppu_addr = 14'h0000;
        #1;
    endtask

    // One bus cycle with the given qualifier; returns at the following negedge.
    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic acc);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_access = acc;
        @(negedge clk);
        cpu_access = 1'b0;
        cpu_addr = 16'h8000;
        ppu_addr = 14'h0000;
        #1;
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 mode", int'(mode_alt), 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36]) do_reset();
            else bus(VEC[i][34:19], VEC[i][18:11], VEC[i][35]);
            chk($sformatf("table row %0d prg bank", i), int'(prg_addr[18:15]), int'(VEC[i][10:7]));
            chk($sformatf("table row %0d chr bank", i), int'(chr_addr[18:13]), int'(VEC[i][6:1]));
            chk($sformatf("table row %0d mirroring", i), int'(mirror_horiz), int'(VEC[i][0]));
        end
        chk("R8 mode flag", int'(mode_alt), 1);

        // R9: address composition, state prg F, chr 3F.
        cpu_addr = 16'hABCD; ppu_addr = 14'h1ABC; #1;
        chk("R9 prg_ce high", int'(prg_ce), 1);
        chk("R9 prg_addr", int'(prg_addr), int'({4'hF, 15'h2BCD}));
        chk("R9 chr_addr", int'(chr_addr), int'({6'h3F, 13'h1ABC}));
        cpu_addr = 16'h1234; #1;
        chk("R9 prg_ce low", int'(prg_ce), 0);

        // R10: vertical mirroring follows ppu A10.
        ppu_addr = 14'h0400; #1;
        chk("R10 vertical a10", int'(ciram_a10), 1);
        ppu_addr = 14'h0800; #1;
        chk("R10 vertical a11 ignored", int'(ciram_a10), 0);

        // R10: horizontal mirroring follows ppu A11.
        do_reset();
        bus(16'hFF85, 8'h80, 1'b1);
        ppu_addr = 14'h0800; #1;
        chk("R10 horizontal a11", int'(ciram_a10), 1);
        ppu_addr = 14'h0400; #1;
        chk("R10 horizontal a10 ignored", int'(ciram_a10), 0);

        // R11: the capturing cycle itself still shows the old bank.
        do_reset();
        @(negedge clk);
        cpu_addr = 16'hFF80; cpu_data = 8'h03; cpu_access = 1'b1; #1;
        chk("R11 old bank during access", int'(prg_addr), int'({4'h0, 15'h7F80}));
        @(negedge clk);
        #1;
        chk("R11 new bank after edge", int'(prg_addr[18:15]), 3);
        cpu_access = 1'b0;
        chk("R7 chr after load 03", int'(chr_addr[18:13]), 12);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule